// File: doc/BRIEF.md
# Marker-Steered Pathway Router

This block sits in a node of a two-dimensional mesh or torus and decides where each newly opened pathway goes next. Four input lanes, one for each direction of travel, deliver words tagged as pathway-open markers, payload words or pathway-close markers. When an open marker arrives, its address field is compared against a two-entry match table. One entry holds this node's own address and the other holds the node's origin identity. From that comparison the lane either keeps the pathway travelling the way it came, delivers it to the local processor, turns it onto a new heading, or drops it because it has come back to where it started.

A pathway that leaves the node needs an outgoing channel. The lane takes the lowest free channel from a shared pool kept for each output direction, and it waits with its input held back while that pool is empty. The chosen direction and channel are kept in the lane's link record, so every payload word after the marker follows the same link. The close marker travels out along the link and hands the channel back to the pool. Headers carry only the turn points and the destination. On a turn, the matching marker is consumed and the next word becomes the marker that goes out.

Top module: `pathway_router`

## Requirements
- R1: After reset every lane accepts input (`in_ready` high), no forward, arrival or loop output is asserted, and every channel of every direction is free.
- R2: An open marker (kind 1) whose address bits [15:0] match neither `node_addr` nor `origin_id` leaves on the direction equal to its lane index (0 east, 1 west, 2 north, 3 south). It appears on the forward outputs unchanged, two clock edges after the edge that accepted it. Bit 18 has no effect on a miss.
- R3: An open marker matching `node_addr` with bit 18 set raises `arrive` for exactly one cycle, one edge after acceptance. The words that follow, up to and including the close marker (kind 2), are forwarded with `fwd_local` set.
- R4: An open marker matching `node_addr` with bit 18 clear is discarded. The next word on that lane, whatever its kind, is sent as an open marker (kind 1) on the direction in bits [17:16]. It appears three edges after the first marker was accepted when the next word is offered at once, one edge more than R2.
- R5: An open marker matching `origin_id` but not `node_addr` raises `loop_det` for one cycle. Every word up to and including the next close marker is then discarded with nothing forwarded, and the lane returns to accepting new markers.
- R6: An outgoing pathway takes the lowest-numbered free channel of its direction. With none free, the lane keeps `in_ready` low and forwards nothing. A channel freed by a close marker can be granted on the next edge.
- R7: Payload words (kind 0) and the close marker on a bound lane are forwarded one edge after acceptance, with the same direction and channel as the open marker. Forwarding the close marker returns the channel to the pool.
- R8: When several lanes claim channels of one direction on the same edge, lower lane indices receive lower channel numbers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| node_addr | input | 16 | This node's address, match entry 0 |
| origin_id | input | 16 | This node's origin identity, match entry 1 |
| in_valid | input | 4 | Word offered, per lane |
| in_kind | input | 4x2 | Word kind per lane: 0 payload, 1 open, 2 close |
| in_word | input | 4xWORD_W | Word per lane |
| in_ready | output | 4 | Lane accepts its word this cycle |
| fwd_valid | output | 4 | Forwarded word valid, per lane |
| fwd_local | output | 4 | Forwarded word goes to the local processor |
| fwd_dir | output | 4x2 | Output direction of the lane's link |
| fwd_chan | output | 4xCH_W | Output channel of the lane's link |
| fwd_kind | output | 4x2 | Kind of the forwarded word |
| fwd_word | output | 4xWORD_W | Forwarded word |
| arrive | output | 4 | One-cycle destination-reached pulse, per lane |
| loop_det | output | 4 | One-cycle returned-to-origin pulse, per lane |

## Verification
The bench builds the router with two channels per direction and a 32-bit word. With that setting every lane can be swept against every turn heading, and a single direction's pool can be emptied by two pathways, so a third one must stall. Two lanes that turn together onto one heading take up both channels on the same edge, which brings the lane-priority order into view. Each outcome is predicted from the lane index, the marker fields and the edge counts in the requirements.

// File: rtl/router_pkg.sv
package router_pkg;
  localparam int ADDR_W   = 16;
  localparam int NDIR     = 4;
  localparam int DIR_W    = 2;
  localparam int TURN_LSB = 16;
  localparam int ACT_BIT  = 18;
  localparam int KIND_W   = 2;

  localparam logic [KIND_W-1:0] KIND_DATA  = 2'd0;
  localparam logic [KIND_W-1:0] KIND_BEGIN = 2'd1;
  localparam logic [KIND_W-1:0] KIND_END   = 2'd2;

  typedef enum logic [2:0] {
    LS_IDLE,
    LS_DECIDE,
    LS_PROMOTE,
    LS_ALLOC,
    LS_BOUND,
    LS_DROP
  } lane_state_e;
endpackage

// File: rtl/sign_cam.sv
module sign_cam #(
  parameter int KEY_W = 16,
  parameter int NENT  = 2
) (
  input  logic [KEY_W-1:0]           key,
  input  logic [NENT-1:0][KEY_W-1:0] entries,
  output logic [NENT-1:0]            hit
);
  // one comparator per stored entry
  for (genvar e = 0; e < NENT; e++) begin : g_ent
    assign hit[e] = (entries[e] == key);
  end
endmodule

// File: rtl/chan_pool.sv
module chan_pool
  import router_pkg::*;
#(
  parameter int NLANE = 4,
  parameter int NCH   = 2,
  parameter int CH_W  = 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NLANE-1:0]            req,
  input  logic [NLANE-1:0][DIR_W-1:0] req_dir,
  output logic [NLANE-1:0]            gnt,
  output logic [NLANE-1:0][CH_W-1:0]  gnt_chan,
  input  logic [NLANE-1:0]            rel,
  input  logic [NLANE-1:0][DIR_W-1:0] rel_dir,
  input  logic [NLANE-1:0][CH_W-1:0]  rel_chan,
  output logic [NDIR-1:0][NCH-1:0]    free_q
);
  logic [NDIR-1:0][NCH-1:0] avail;
  logic [NDIR-1:0][NCH-1:0] free_d;
  logic                     free_en;

  // lanes are served in index order; each takes the lowest free channel
  always_comb begin
    avail    = free_q;
    gnt      = '0;
    gnt_chan = '0;
    for (int l = 0; l < NLANE; l++) begin
      if (req[l] && (|avail[req_dir[l]])) begin
        for (int c = NCH - 1; c >= 0; c--) begin
          if (avail[req_dir[l]][c]) gnt_chan[l] = CH_W'(c);
        end
        gnt[l] = 1'b1;
        avail[req_dir[l]][gnt_chan[l]] = 1'b0;
      end
    end
    free_d = avail;
    for (int l = 0; l < NLANE; l++) begin
      if (rel[l]) free_d[rel_dir[l]][rel_chan[l]] = 1'b1;
    end
  end

  assign free_en = (|req) | (|rel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       free_q <= '1;
    else if (free_en) free_q <= free_d;
  end
endmodule

// File: rtl/path_lane.sv
module path_lane
  import router_pkg::*;
#(
  parameter int LANE   = 0,
  parameter int WORD_W = 32,
  parameter int CH_W   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] node_addr,
  input  logic [ADDR_W-1:0] origin_id,
  input  logic              in_valid,
  input  logic [KIND_W-1:0] in_kind,
  input  logic [WORD_W-1:0] in_word,
  output logic              in_ready,
  output logic              req,
  output logic [DIR_W-1:0]  req_dir,
  input  logic              gnt,
  input  logic [CH_W-1:0]   gnt_chan,
  output logic              rel,
  output logic [DIR_W-1:0]  rel_dir,
  output logic [CH_W-1:0]   rel_chan,
  output logic              fwd_valid,
  output logic              fwd_local,
  output logic [DIR_W-1:0]  fwd_dir,
  output logic [CH_W-1:0]   fwd_chan,
  output logic [KIND_W-1:0] fwd_kind,
  output logic [WORD_W-1:0] fwd_word,
  output logic              arrive,
  output logic              loop_det,
  output logic              bound,
  output logic              alloc
);
  lane_state_e state_q, state_d;
  logic [WORD_W-1:0] mark_q;
  logic              mark_en;
  logic [DIR_W-1:0]  dir_q, dir_d;
  logic              dir_en;
  logic              loc_q, loc_d, loc_en;
  logic [CH_W-1:0]   chan_q;
  logic              chan_en;
  logic              fv_d;
  logic [KIND_W-1:0] fk_d;
  logic [WORD_W-1:0] fw_d;
  logic              fwd_en;
  logic              arr_d, lp_d;
  logic              acc;
  logic [1:0]        hit;

  sign_cam #(.KEY_W(ADDR_W), .NENT(2)) u_cam (
    .key     (mark_q[ADDR_W-1:0]),
    .entries ({origin_id, node_addr}),
    .hit     (hit)
  );

  assign in_ready = (state_q == LS_IDLE) || (state_q == LS_PROMOTE) ||
                    (state_q == LS_BOUND) || (state_q == LS_DROP);
  assign acc      = in_valid & in_ready;

  always_comb begin
    state_d = state_q;
    mark_en = 1'b0;
    dir_en  = 1'b0;
    dir_d   = dir_q;
    loc_en  = 1'b0;
    loc_d   = loc_q;
    chan_en = 1'b0;
    req     = 1'b0;
    rel     = 1'b0;
    fv_d    = 1'b0;
    fk_d    = in_kind;
    fw_d    = in_word;
    arr_d   = 1'b0;
    lp_d    = 1'b0;
    case (state_q)
      LS_IDLE: begin
        if (acc && (in_kind == KIND_BEGIN)) begin
          mark_en = 1'b1;
          state_d = LS_DECIDE;
        end
      end
      LS_DECIDE: begin
        if (hit[0]) begin
          if (mark_q[ACT_BIT]) begin
            loc_en  = 1'b1;
            loc_d   = 1'b1;
            arr_d   = 1'b1;
            state_d = LS_BOUND;
          end else begin
            dir_en  = 1'b1;
            dir_d   = mark_q[TURN_LSB +: DIR_W];
            state_d = LS_PROMOTE;
          end
        end else if (hit[1]) begin
          lp_d    = 1'b1;
          state_d = LS_DROP;
        end else begin
          dir_en  = 1'b1;
          dir_d   = DIR_W'(LANE);
          state_d = LS_ALLOC;
        end
      end
      LS_PROMOTE: begin
        if (acc) begin
          mark_en = 1'b1;
          state_d = LS_ALLOC;
        end
      end
      LS_ALLOC: begin
        req = 1'b1;
        if (gnt) begin
          chan_en = 1'b1;
          loc_en  = 1'b1;
          loc_d   = 1'b0;
          fv_d    = 1'b1;
          fk_d    = KIND_BEGIN;
          fw_d    = mark_q;
          state_d = LS_BOUND;
        end
      end
      LS_BOUND: begin
        if (acc) begin
          fv_d = 1'b1;
          if (in_kind == KIND_END) begin
            rel     = ~loc_q;
            state_d = LS_IDLE;
          end
        end
      end
      LS_DROP: begin
        if (acc && (in_kind == KIND_END)) state_d = LS_IDLE;
      end
      default: state_d = LS_IDLE;
    endcase
  end

  assign fwd_en = fv_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= LS_IDLE;
      mark_q    <= '0;
      dir_q     <= '0;
      loc_q     <= 1'b0;
      chan_q    <= '0;
      fwd_valid <= 1'b0;
      fwd_kind  <= '0;
      fwd_word  <= '0;
      arrive    <= 1'b0;
      loop_det  <= 1'b0;
    end else begin
      state_q   <= state_d;
      fwd_valid <= fv_d;
      arrive    <= arr_d;
      loop_det  <= lp_d;
      if (mark_en) mark_q <= in_word;
      if (dir_en)  dir_q  <= dir_d;
      if (loc_en)  loc_q  <= loc_d;
      if (chan_en) chan_q <= gnt_chan;
      if (fwd_en) begin
        fwd_kind <= fk_d;
        fwd_word <= fw_d;
      end
    end
  end

  assign req_dir   = dir_q;
  assign rel_dir   = dir_q;
  assign rel_chan  = chan_q;
  assign fwd_dir   = dir_q;
  assign fwd_chan  = chan_q;
  assign fwd_local = loc_q;
  assign bound     = (state_q == LS_BOUND);
  assign alloc     = (state_q == LS_ALLOC);
endmodule

// File: rtl/pathway_router.sv
module pathway_router
  import router_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int NCH    = 2,
  parameter int NLANE  = 4,
  parameter int CH_W   = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [ADDR_W-1:0]            node_addr,
  input  logic [ADDR_W-1:0]            origin_id,
  input  logic [NLANE-1:0]             in_valid,
  input  logic [NLANE-1:0][KIND_W-1:0] in_kind,
  input  logic [NLANE-1:0][WORD_W-1:0] in_word,
  output logic [NLANE-1:0]             in_ready,
  output logic [NLANE-1:0]             fwd_valid,
  output logic [NLANE-1:0]             fwd_local,
  output logic [NLANE-1:0][DIR_W-1:0]  fwd_dir,
  output logic [NLANE-1:0][CH_W-1:0]   fwd_chan,
  output logic [NLANE-1:0][KIND_W-1:0] fwd_kind,
  output logic [NLANE-1:0][WORD_W-1:0] fwd_word,
  output logic [NLANE-1:0]             arrive,
  output logic [NLANE-1:0]             loop_det
);
  logic [NLANE-1:0]            req, gnt, rel;
  logic [NLANE-1:0][DIR_W-1:0] req_dir, rel_dir;
  logic [NLANE-1:0][CH_W-1:0]  gnt_chan, rel_chan;
  logic [NLANE-1:0]            lane_bound, lane_alloc;
  logic [NDIR-1:0][NCH-1:0]    pool_free;

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    path_lane #(.LANE(l), .WORD_W(WORD_W), .CH_W(CH_W)) u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .node_addr (node_addr),
      .origin_id (origin_id),
      .in_valid  (in_valid[l]),
      .in_kind   (in_kind[l]),
      .in_word   (in_word[l]),
      .in_ready  (in_ready[l]),
      .req       (req[l]),
      .req_dir   (req_dir[l]),
      .gnt       (gnt[l]),
      .gnt_chan  (gnt_chan[l]),
      .rel       (rel[l]),
      .rel_dir   (rel_dir[l]),
      .rel_chan  (rel_chan[l]),
      .fwd_valid (fwd_valid[l]),
      .fwd_local (fwd_local[l]),
      .fwd_dir   (fwd_dir[l]),
      .fwd_chan  (fwd_chan[l]),
      .fwd_kind  (fwd_kind[l]),
      .fwd_word  (fwd_word[l]),
      .arrive    (arrive[l]),
      .loop_det  (loop_det[l]),
      .bound     (lane_bound[l]),
      .alloc     (lane_alloc[l])
    );
  end

  chan_pool #(.NLANE(NLANE), .NCH(NCH), .CH_W(CH_W)) u_pool (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .req_dir  (req_dir),
    .gnt      (gnt),
    .gnt_chan (gnt_chan),
    .rel      (rel),
    .rel_dir  (rel_dir),
    .rel_chan (rel_chan),
    .free_q   (pool_free)
  );
endmodule

// File: rtl/pathway_router_chk.sv
module pathway_router_chk
  import router_pkg::*;
#(
  parameter int NLANE = 4,
  parameter int NCH   = 2,
  parameter int CH_W  = 1
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [NLANE-1:0]            bound,
  input logic [NLANE-1:0]            alloc,
  input logic [NLANE-1:0]            loc,
  input logic [NLANE-1:0][DIR_W-1:0] link_dir,
  input logic [NLANE-1:0][CH_W-1:0]  link_chan,
  input logic [NDIR-1:0][NCH-1:0]    free,
  input logic [NLANE-1:0]            rel,
  input logic [NLANE-1:0][DIR_W-1:0] rel_dir,
  input logic [NLANE-1:0][CH_W-1:0]  rel_chan,
  input logic [NLANE-1:0]            arrive,
  input logic [NLANE-1:0]            loop_det,
  input logic [NLANE-1:0]            fwd_valid,
  input logic [NLANE-1:0]            in_ready
);
  for (genvar l = 0; l < NLANE; l++) begin : g_chk
    // R6: a channel held by a bound outgoing link is never in the free set
    a_r6_link_held: assert property (@(posedge clk) disable iff (!rst_n)
      (bound[l] && !loc[l]) |-> !free[link_dir[l]][link_chan[l]]);
    // R6: a lane waiting for a channel holds its input back
    a_r6_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      alloc[l] |-> !in_ready[l]);
    // R7: only a channel in use is ever handed back
    a_r7_release_owned: assert property (@(posedge clk) disable iff (!rst_n)
      rel[l] |-> !free[rel_dir[l]][rel_chan[l]]);
    // R3: the arrival pulse carries no forwarded word with it
    a_r3_arrive_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      arrive[l] |-> !fwd_valid[l]);
    // R5: after a loop is seen, nothing is forwarded on the next cycle
    a_r5_loop_silent: assert property (@(posedge clk) disable iff (!rst_n)
      loop_det[l] |=> !fwd_valid[l]);
  end
endmodule

bind pathway_router pathway_router_chk #(.NLANE(NLANE), .NCH(NCH), .CH_W(CH_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bound     (lane_bound),
  .alloc     (lane_alloc),
  .loc       (fwd_local),
  .link_dir  (fwd_dir),
  .link_chan (fwd_chan),
  .free      (pool_free),
  .rel       (rel),
  .rel_dir   (rel_dir),
  .rel_chan  (rel_chan),
  .arrive    (arrive),
  .loop_det  (loop_det),
  .fwd_valid (fwd_valid),
  .in_ready  (in_ready)
);

// File: tb/pathway_router_bench.sv
`timescale 1ns/1ps
module pathway_router_bench;
  localparam int WORD_W = 32;
  localparam int NCH    = 2;
  localparam int CH_W   = 1;
  localparam logic [15:0] NODE = 16'h0A0B;
  localparam logic [15:0] ORIG = 16'h0C0D;

  logic                   clk = 1'b0;
  logic                   rst_n;
  logic [3:0]             in_valid;
  logic [3:0][1:0]        in_kind;
  logic [3:0][WORD_W-1:0] in_word;
  logic [3:0]             in_ready, fwd_valid, fwd_local, arrive, loop_det;
  logic [3:0][1:0]        fwd_dir, fwd_kind;
  logic [3:0][CH_W-1:0]   fwd_chan;
  logic [3:0][WORD_W-1:0] fwd_word;

  int nvec = 0;
  int nerr = 0;

  always #2 clk = ~clk;

  pathway_router #(.WORD_W(WORD_W), .NCH(NCH)) u_pathway_router (
    .clk(clk), .rst_n(rst_n), .node_addr(NODE), .origin_id(ORIG),
    .in_valid(in_valid), .in_kind(in_kind), .in_word(in_word), .in_ready(in_ready),
    .fwd_valid(fwd_valid), .fwd_local(fwd_local), .fwd_dir(fwd_dir), .fwd_chan(fwd_chan),
    .fwd_kind(fwd_kind), .fwd_word(fwd_word), .arrive(arrive), .loop_det(loop_det)
  );

  function automatic logic [WORD_W-1:0] mk(logic act, logic [1:0] td, logic [15:0] a);
    return {13'h0, act, td, a};
  endfunction

  task automatic chk(string r, logic [63:0] act, logic [63:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  // caller is at a negative edge; returns at the negative edge after acceptance
  task automatic put(int l, logic [1:0] k, logic [WORD_W-1:0] w);
    in_valid[l] = 1'b1;
    in_kind[l]  = k;
    in_word[l]  = w;
    while (!in_ready[l]) @(negedge clk);
    @(negedge clk);
    in_valid[l] = 1'b0;
  endtask

  task automatic expect_fwd(string r, int l, logic loc, logic [1:0] d, logic [CH_W-1:0] c,
                            logic [1:0] k, logic [WORD_W-1:0] w);
    chk({r, " valid"}, 64'(fwd_valid[l]), 64'd1);
    chk({r, " local"}, 64'(fwd_local[l]), 64'(loc));
    if (!loc) begin
      chk({r, " dir"}, 64'(fwd_dir[l]), 64'(d));
      chk({r, " chan"}, 64'(fwd_chan[l]), 64'(c));
    end
    chk({r, " kind"}, 64'(fwd_kind[l]), 64'(k));
    chk({r, " word"}, 64'(fwd_word[l]), 64'(w));
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL R1 watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n    = 1'b0;
    in_valid = '0;
    in_kind  = '0;
    in_word  = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 ready", 64'(in_ready), 64'hF);
    chk("R1 fwd", 64'(fwd_valid), 64'h0);
    chk("R1 pulses", 64'({arrive, loop_det}), 64'h0);

    // R2 / R7: straight-through sweep, both values of the action bit
    for (int l = 0; l < 4; l++) begin
      for (int a = 0; a < 2; a++) begin
        logic [WORD_W-1:0] m;
        m = mk(a[0], 2'(l + 1), 16'h1230 + 16'(l));
        put(l, 2'd1, m);
        chk("R2 no early fwd", 64'(fwd_valid[l]), 64'd0);
        @(negedge clk);
        @(negedge clk);
        expect_fwd("R2 straight", l, 1'b0, 2'(l), 1'b0, 2'd1, m);
        for (int j = 0; j < 2; j++) begin
          put(l, 2'd0, 32'hD000_0000 + 32'(l * 16 + j));
          expect_fwd("R7 payload", l, 1'b0, 2'(l), 1'b0, 2'd0, 32'hD000_0000 + 32'(l * 16 + j));
        end
        put(l, 2'd2, 32'hE000_0000 + 32'(l));
        expect_fwd("R7 close", l, 1'b0, 2'(l), 1'b0, 2'd2, 32'hE000_0000 + 32'(l));
      end
    end

    // R4: turn sweep over every lane and heading
    for (int l = 0; l < 4; l++) begin
      for (int td = 0; td < 4; td++) begin
        logic [WORD_W-1:0] nw;
        nw = 32'h5A00_0000 + 32'(l * 4 + td);
        put(l, 2'd1, mk(1'b0, 2'(td), NODE));
        put(l, 2'd0, nw);
        chk("R4 marker consumed", 64'(fwd_valid[l]), 64'd0);
        @(negedge clk);
        expect_fwd("R4 turn", l, 1'b0, 2'(td), 1'b0, 2'd1, nw);
        put(l, 2'd2, 32'h0);
        expect_fwd("R7 turn close", l, 1'b0, 2'(td), 1'b0, 2'd2, 32'h0);
      end
    end

    // R3: local delivery on every lane
    for (int l = 0; l < 4; l++) begin
      put(l, 2'd1, mk(1'b1, 2'd3, NODE));
      chk("R3 arrive early", 64'(arrive[l]), 64'd0);
      @(negedge clk);
      chk("R3 arrive", 64'(arrive[l]), 64'd1);
      @(negedge clk);
      chk("R3 arrive one cycle", 64'(arrive[l]), 64'd0);
      put(l, 2'd0, 32'h1111_0000 + 32'(l));
      expect_fwd("R3 local payload", l, 1'b1, 2'd0, 1'b0, 2'd0, 32'h1111_0000 + 32'(l));
      put(l, 2'd2, 32'h2222_0000 + 32'(l));
      expect_fwd("R3 local close", l, 1'b1, 2'd0, 1'b0, 2'd2, 32'h2222_0000 + 32'(l));
    end

    // R5: return to origin on every lane
    for (int l = 0; l < 4; l++) begin
      put(l, 2'd1, mk(1'b0, 2'd2, ORIG));
      @(negedge clk);
      chk("R5 loop pulse", 64'(loop_det[l]), 64'd1);
      put(l, 2'd0, 32'h3333_3333);
      chk("R5 payload dropped", 64'(fwd_valid[l]), 64'd0);
      put(l, 2'd2, 32'h4444_4444);
      chk("R5 close dropped", 64'(fwd_valid[l]), 64'd0);
      chk("R5 lane free", 64'(in_ready[l]), 64'd1);
    end

    // R6: empty the east pool, third claimant stalls until a close
    put(0, 2'd1, mk(1'b0, 2'd0, 16'h7777));
    @(negedge clk);
    @(negedge clk);
    expect_fwd("R6 first chan", 0, 1'b0, 2'd0, 1'b0, 2'd1, mk(1'b0, 2'd0, 16'h7777));
    put(1, 2'd1, mk(1'b0, 2'd0, NODE));
    put(1, 2'd0, 32'hABCD_0001);
    @(negedge clk);
    expect_fwd("R6 second chan", 1, 1'b0, 2'd0, 1'b1, 2'd1, 32'hABCD_0001);
    put(2, 2'd1, mk(1'b0, 2'd0, NODE));
    put(2, 2'd0, 32'hABCD_0002);
    repeat (3) @(negedge clk);
    chk("R6 stall fwd", 64'(fwd_valid[2]), 64'd0);
    chk("R6 stall ready", 64'(in_ready[2]), 64'd0);
    put(0, 2'd2, 32'h0);
    chk("R6 not before free", 64'(fwd_valid[2]), 64'd0);
    @(negedge clk);
    expect_fwd("R6 freed chan", 2, 1'b0, 2'd0, 1'b0, 2'd1, 32'hABCD_0002);
    put(1, 2'd2, 32'h0);
    put(2, 2'd2, 32'h0);

    // R8: lanes 2 and 3 turn west on the same edge
    in_valid[2] = 1'b1; in_kind[2] = 2'd1; in_word[2] = mk(1'b0, 2'd1, NODE);
    in_valid[3] = 1'b1; in_kind[3] = 2'd1; in_word[3] = mk(1'b0, 2'd1, NODE);
    @(negedge clk);
    in_kind[2] = 2'd0; in_word[2] = 32'hC0DE_0002;
    in_kind[3] = 2'd0; in_word[3] = 32'hC0DE_0003;
    @(negedge clk);
    @(negedge clk);
    in_valid[2] = 1'b0;
    in_valid[3] = 1'b0;
    @(negedge clk);
    expect_fwd("R8 lower lane", 2, 1'b0, 2'd1, 1'b0, 2'd1, 32'hC0DE_0002);
    expect_fwd("R8 higher lane", 3, 1'b0, 2'd1, 1'b1, 2'd1, 32'hC0DE_0003);
    put(2, 2'd2, 32'h0);
    put(3, 2'd2, 32'h0);
    @(negedge clk);
    chk("R1 idle again", 64'(in_ready), 64'hF);

    finish_run();
  end
endmodule